// File: doc/BRIEF.md
# Two-level page table walker

This block turns a 32-bit device virtual address into a physical address. It walks a two-level translation table held in memory. A requester hands over a virtual address and an access direction (read or write) on a valid/ready request channel. The walker fetches the first-level entry through a single-word memory read port. If that entry is present, it fetches the second-level entry. It then checks presence and the permission bit for the access direction, and returns one result on a valid/ready result channel.

A result is either a translation or a fault. A translation carries the physical address and the six cache/allocate hint bits of the leaf entry. A fault echoes the virtual address and the direction of the access that failed. The directory base is a plain input. It must stay steady while a walk is in flight. Only bits [31:12] of the directory base are used.

Handshake rules on every channel: a transfer happens on a rising clock edge where valid and ready are both high. The walker holds `mem_req_valid` and `mem_req_addr` steady until `mem_req_ready` is seen. It holds `rsp_valid` and every result field steady until `rsp_ready` is seen. `req_ready` is high only while no walk is in flight, so the requester is back-pressured for the whole walk. Memory responses are not back-pressured. The walker accepts `mem_rsp_valid` in any cycle after its read has been taken.

Top module: `pgw_top`

## Requirements
- R1: After reset, `req_ready` is 1 and both `mem_req_valid` and `rsp_valid` are 0.
- R2: The first fetch of a walk reads address {dir_base[31:12], 12'h000} + 4 * vaddr[31:22]. The low 12 bits of `dir_base` have no effect.
- R3: The second fetch reads address {L1[31:12], 12'h000} + 4 * vaddr[21:12], where L1 is the first-level entry. The low 12 bits of L1 have no effect on the address.
- R4: A first-level entry with bit 0 (present) at 0 ends the walk with `rsp_fault`=1. No second fetch is made. `rsp_vaddr` equals the request address and `rsp_write` equals the request direction.
- R5: A second-level entry with bit 0 at 0 ends the walk with a fault, reported the same way as in R4.
- R6: In a present leaf, bit 1 grants read and bit 2 grants write. A read with bit 1 at 0, or a write with bit 2 at 0, gives a fault reported as in R4.
- R7: A successful walk returns `rsp_fault`=0, `rsp_paddr` = {leaf[31:12], vaddr[11:0]} and `rsp_hints` = leaf[8:3].
- R8: At most one memory read is outstanding. `mem_req_valid` stays 0 from the accepted read until its response arrives. While `mem_req_ready` is 0, `mem_req_valid` and `mem_req_addr` hold.
- R9: `req_ready` is 1 exactly when no walk is in flight. Each accepted request yields exactly one result, in order. While `rsp_ready` is 0, `rsp_valid` and all result fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dir_base | input | 32 | First-level directory base; bits [31:12] used |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| mem_req_valid | output | 1 | Table entry read request |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 32 | Table entry returned by memory |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_fault | output | 1 | 1 = fault, 0 = translation |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_hints | output | 6 | Leaf bits [8:3] (0 on fault) |
| rsp_vaddr | output | 32 | Virtual address of the walk |
| rsp_write | output | 1 | Direction of the walk |

## Verification
The bench builds the walker with its default parameters: 32-bit addresses, a 12-bit page offset (and so 10-bit indices at each level), and a 6-bit hint field starting at bit 3. These values bring within reach the full-width corner cases: index 1023 at both levels with an all-ones offset, index 0 everywhere, and flag junk in the low 12 bits of the directory base and of first-level entries. A random phase applies back-pressure on both the memory port and the result port, with varied response latency. This exercises the hold rules and the single outstanding read.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_L1_ASK,
    S_L1_WAIT,
    S_L2_ASK,
    S_L2_WAIT,
    S_DONE
  } walk_state_e;

  localparam int PRESENT_BIT = 0;
  localparam int RD_BIT      = 1;
  localparam int WR_BIT      = 2;
  localparam int ENT_SHIFT   = 2;  // entries are four bytes
endpackage

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen
  import pgw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] aligned;
  logic [ADDR_W-1:0] offs;

  // table bases are page aligned; any flag bits below are dropped
  assign aligned = {base_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign offs    = ADDR_W'({idx_i, {ENT_SHIFT{1'b0}}});
  assign addr_o  = aligned + offs;
endmodule

// File: rtl/pgw_entry_check.sv
module pgw_entry_check
  import pgw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] entry_i,
  input  logic              is_leaf_i,
  input  logic              is_write_i,
  output logic              fault_o
);
  logic perm_ok;

  assign perm_ok = is_write_i ? entry_i[WR_BIT] : entry_i[RD_BIT];
  assign fault_o = !entry_i[PRESENT_BIT] || (is_leaf_i && !perm_ok);
endmodule

// File: rtl/pgw_walk_fsm.sv
module pgw_walk_fsm
  import pgw_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 12,
  parameter int HINT_LSB = 3,
  parameter int HINT_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  input  logic              step_fault,
  output logic              on_leaf,
  output logic [ADDR_W-1:0] va_q,
  output logic              wr_q,
  output logic [ADDR_W-1:0] dir_ent_q,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_fault,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [HINT_W-1:0] rsp_hints
);
  walk_state_e       st;
  logic              fault_q;
  logic [ADDR_W-1:0] pa_q;
  logic [HINT_W-1:0] hint_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      va_q      <= '0;
      wr_q      <= 1'b0;
      dir_ent_q <= '0;
      fault_q   <= 1'b0;
      pa_q      <= '0;
      hint_q    <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q <= req_vaddr;
          wr_q <= req_write;
          st   <= S_L1_ASK;
        end
        S_L1_ASK: if (mem_req_ready) st <= S_L1_WAIT;
        S_L1_WAIT: if (mem_rsp_valid) begin
          if (step_fault) begin
            fault_q <= 1'b1;
            pa_q    <= '0;
            hint_q  <= '0;
            st      <= S_DONE;
          end else begin
            dir_ent_q <= mem_rsp_data;
            st        <= S_L2_ASK;
          end
        end
        S_L2_ASK: if (mem_req_ready) st <= S_L2_WAIT;
        S_L2_WAIT: if (mem_rsp_valid) begin
          fault_q <= step_fault;
          pa_q    <= step_fault ? '0 : {mem_rsp_data[ADDR_W-1:OFF_W], va_q[OFF_W-1:0]};
          hint_q  <= step_fault ? '0 : mem_rsp_data[HINT_LSB +: HINT_W];
          st      <= S_DONE;
        end
        S_DONE: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_L1_ASK) || (st == S_L2_ASK);
  assign on_leaf       = (st == S_L2_ASK) || (st == S_L2_WAIT);
  assign rsp_valid     = (st == S_DONE);
  assign rsp_fault     = fault_q;
  assign rsp_paddr     = pa_q;
  assign rsp_hints     = hint_q;

  // R8: a stalled fetch keeps its address
  p_fetch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(va_q) && $stable(on_leaf));

  // R8: after a fetch is taken, no new fetch until a response
  p_one_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  // R9: a stalled result holds
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_fault) && $stable(rsp_paddr)
      && $stable(rsp_hints) && $stable(va_q) && $stable(wr_q));

  // R4: a walk ending at the first level is always a fault
  p_l1_end_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && !$past(on_leaf) |-> rsp_fault);

  // R6: a translation only follows a present, permitted leaf
  p_leaf_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && !rsp_fault |-> $past(on_leaf) && $past(mem_rsp_data[PRESENT_BIT])
      && (wr_q ? $past(mem_rsp_data[WR_BIT]) : $past(mem_rsp_data[RD_BIT])));

  // R7: page number comes from the leaf that ended the walk
  p_paddr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && !rsp_fault |-> rsp_paddr[ADDR_W-1:OFF_W] == $past(mem_rsp_data[ADDR_W-1:OFF_W]));
endmodule

// File: rtl/pgw_top.sv
module pgw_top
  import pgw_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 12,
  parameter int HINT_LSB = 3,
  parameter int HINT_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] dir_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_fault,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [HINT_W-1:0] rsp_hints,
  output logic [ADDR_W-1:0] rsp_vaddr,
  output logic              rsp_write
);
  localparam int LEVELS = 2;
  localparam int IDX_W  = (ADDR_W - OFF_W) / LEVELS;

  logic              on_leaf;
  logic              step_fault;
  logic [ADDR_W-1:0] va_q;
  logic              wr_q;
  logic [ADDR_W-1:0] dir_ent_q;
  logic [ADDR_W-1:0] lvl_base [LEVELS];
  logic [ADDR_W-1:0] lvl_addr [LEVELS];

  assign lvl_base[0] = dir_base;
  assign lvl_base[1] = dir_ent_q;

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    pgw_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_ag (
      .base_i (lvl_base[l]),
      .idx_i  (va_q[ADDR_W-1-l*IDX_W -: IDX_W]),
      .addr_o (lvl_addr[l])
    );
  end

  assign mem_req_addr = on_leaf ? lvl_addr[1] : lvl_addr[0];

  pgw_entry_check #(.ADDR_W(ADDR_W)) u_chk (
    .entry_i    (mem_rsp_data),
    .is_leaf_i  (on_leaf),
    .is_write_i (wr_q),
    .fault_o    (step_fault)
  );

  pgw_walk_fsm #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .HINT_LSB(HINT_LSB), .HINT_W(HINT_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .req_write     (req_write),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .step_fault    (step_fault),
    .on_leaf       (on_leaf),
    .va_q          (va_q),
    .wr_q          (wr_q),
    .dir_ent_q     (dir_ent_q),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_fault     (rsp_fault),
    .rsp_paddr     (rsp_paddr),
    .rsp_hints     (rsp_hints)
  );

  assign rsp_vaddr = va_q;
  assign rsp_write = wr_q;

  // R9: no new request is taken while a result waits
  p_busy_no_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
endmodule

// File: tb/pgw_top_test.sv
module pgw_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] dir_base = 32'h0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = 32'h0;
  logic        req_write = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = 32'h0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_fault;
  logic [31:0] rsp_paddr;
  logic [5:0]  rsp_hints;
  logic [31:0] rsp_vaddr;
  logic        rsp_write;

  always #4 clk = ~clk;  // 8 ns period, 125 MHz

  pgw_top uut (
    .clk(clk), .rst_n(rst_n), .dir_base(dir_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr), .rsp_hints(rsp_hints), .rsp_vaddr(rsp_vaddr), .rsp_write(rsp_write)
  );

  bit [31:0] mem [bit [31:0]];
  logic [31:0] xa_q[$];
  string       xa_tag[$];
  logic        ef_q[$];
  logic [31:0] epa_q[$];
  logic [5:0]  eh_q[$];
  logic [31:0] eva_q[$];
  logic        ewr_q[$];
  string       etag_q[$];

  int  vectors = 0;
  int  miscompares = 0;
  bit  stall_mode = 1'b0;
  bit  busy = 1'b0;
  bit  mwait = 1'b0;
  bit  ended = 1'b0;
  int  cnt = 0;
  logic [31:0] pend_a = 32'h0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] va, input bit wr, input logic [31:0] dir);
    logic [31:0] a1, a2, e1, e2;
    bit perm;
    a1 = {dir[31:12], 12'h000} + {20'h0, va[31:22], 2'b00};
    xa_q.push_back(a1); xa_tag.push_back("R2");
    e1 = rd(a1);
    eva_q.push_back(va); ewr_q.push_back(wr);
    if (!e1[0]) begin
      ef_q.push_back(1'b1); epa_q.push_back(32'h0); eh_q.push_back(6'h0); etag_q.push_back("R4");
      return;
    end
    a2 = {e1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
    xa_q.push_back(a2); xa_tag.push_back("R3");
    e2 = rd(a2);
    perm = wr ? e2[2] : e2[1];
    if (!e2[0]) begin
      ef_q.push_back(1'b1); epa_q.push_back(32'h0); eh_q.push_back(6'h0); etag_q.push_back("R5");
    end else if (!perm) begin
      ef_q.push_back(1'b1); epa_q.push_back(32'h0); eh_q.push_back(6'h0); etag_q.push_back("R6");
    end else begin
      ef_q.push_back(1'b0); epa_q.push_back({e2[31:12], va[11:0]}); eh_q.push_back(e2[8:3]);
      etag_q.push_back("R7");
    end
  endfunction

  task automatic issue(input logic [31:0] va, input bit wr);
    model(va, wr, dir_base);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (etag_q.size() != 0 || busy) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // memory model and consumer back-pressure
  always begin
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rd(pend_a);
      end
    end
    mem_req_ready = (cnt == 0) && !mem_rsp_valid && (!stall_mode || $urandom_range(0, 2) != 0);
    if (mem_req_valid === 1'b1 && mem_req_ready) begin
      pend_a = mem_req_addr;
      cnt    = stall_mode ? int'($urandom_range(1, 3)) : 1;
    end
    rsp_ready = !stall_mode || ($urandom_range(0, 1) == 1);
  end

  // reference comparison every clock
  logic        prev_mv = 1'b0, prev_mr = 1'b0, prev_rv = 1'b0, prev_rr = 1'b0;
  logic [31:0] prev_ma = 32'h0, prev_pa = 32'h0, prev_va = 32'h0;
  logic [5:0]  prev_h = 6'h0;
  logic        prev_f = 1'b0, prev_w = 1'b0;

  always begin
    @(negedge clk); #1;
    if (rst_n) begin
      chk(req_ready == !busy, "R9 req_ready only when idle", 64'(req_ready), 64'(!busy));
      if (prev_mv && !prev_mr)
        chk(mem_req_valid && mem_req_addr == prev_ma, "R8 stalled fetch held", 64'(mem_req_addr), 64'(prev_ma));
      if (mwait)
        chk(!mem_req_valid, "R8 single outstanding read", 64'(mem_req_valid), 64'd0);
      if (mem_rsp_valid) mwait = 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        if (xa_q.size() == 0) chk(1'b0, "R4 unexpected fetch", 64'(mem_req_addr), 64'd0);
        else begin
          logic [31:0] ea;
          string t;
          ea = xa_q.pop_front(); t = xa_tag.pop_front();
          chk(mem_req_addr == ea, {t, " entry address"}, 64'(mem_req_addr), 64'(ea));
        end
        mwait = 1'b1;
      end
      if (prev_rv && !prev_rr)
        chk(rsp_valid && rsp_fault == prev_f && rsp_paddr == prev_pa && rsp_hints == prev_h
            && rsp_vaddr == prev_va && rsp_write == prev_w, "R9 stalled result held",
            64'(rsp_paddr), 64'(prev_pa));
      if (rsp_valid && rsp_ready) begin
        if (etag_q.size() == 0) chk(1'b0, "R9 extra result", 64'(rsp_paddr), 64'd0);
        else begin
          logic f; logic [31:0] pa, va; logic [5:0] h; logic w; string t;
          f = ef_q.pop_front(); pa = epa_q.pop_front(); h = eh_q.pop_front();
          va = eva_q.pop_front(); w = ewr_q.pop_front(); t = etag_q.pop_front();
          chk(rsp_fault == f, {t, " fault flag"}, 64'(rsp_fault), 64'(f));
          if (f) begin
            chk(rsp_vaddr == va, {t, " fault vaddr"}, 64'(rsp_vaddr), 64'(va));
            chk(rsp_write == w, {t, " fault direction"}, 64'(rsp_write), 64'(w));
          end else begin
            chk(rsp_paddr == pa, {t, " physical address"}, 64'(rsp_paddr), 64'(pa));
            chk(rsp_hints == h, {t, " hints"}, 64'(rsp_hints), 64'(h));
          end
        end
        busy = 1'b0;
      end
      if (req_valid && req_ready) busy = 1'b1;
      prev_mv = mem_req_valid; prev_mr = mem_req_ready; prev_ma = mem_req_addr;
      prev_rv = rsp_valid; prev_rr = rsp_ready; prev_f = rsp_fault; prev_pa = rsp_paddr;
      prev_h = rsp_hints; prev_va = rsp_vaddr; prev_w = rsp_write;
    end
  end

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog expired", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    dir_base = 32'h0001_0ABC;  // low bits must not matter (R2)
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(req_ready == 1'b1, "R1 reset req_ready", 64'(req_ready), 64'd1);
    chk(mem_req_valid == 1'b0, "R1 reset mem_req_valid", 64'(mem_req_valid), 64'd0);
    chk(rsp_valid == 1'b0, "R1 reset rsp_valid", 64'(rsp_valid), 64'd0);

    mem[32'h0001_0004] = 32'h0002_0FF1;  // junk low bits in L1 (R3)
    mem[32'h0002_000C] = 32'h1234_51FB;  // read only, all hints
    mem[32'h0002_001C] = 32'h5555_5006;  // leaf absent (R5)
    mem[32'h0002_0020] = 32'hABCD_E005;  // write only
    mem[32'h0001_0FFC] = 32'h0003_0001;
    mem[32'h0003_0FFC] = 32'hFEDC_B007;
    mem[32'h0001_0000] = 32'h0004_0001;
    mem[32'h0004_0000] = 32'h0000_1003;

    issue(32'h0040_3123, 1'b0);  // R7 translation with hints
    issue(32'h0040_3123, 1'b1);  // R6 write denied
    issue(32'h0140_0456, 1'b1);  // R4 directory entry absent
    issue(32'h0040_7ABC, 1'b0);  // R5 leaf absent
    issue(32'h0040_8DDD, 1'b1);  // R6 write granted
    issue(32'h0040_8DDD, 1'b0);  // R6 read denied
    issue(32'hFFFF_FFFF, 1'b1);  // top indices
    issue(32'h0000_0000, 1'b0);  // zero indices
    wait_idle();

    stall_mode = 1'b1;
    for (int i = 0; i < 80; i++) begin
      logic [31:0] va, e1, e2, a1, a2;
      bit wr;
      wait_idle();
      va = $urandom; wr = 1'($urandom_range(0, 1));
      e1 = $urandom; if ($urandom_range(0, 7) != 0) e1[0] = 1'b1;
      e2 = $urandom; if ($urandom_range(0, 7) != 0) e2[0] = 1'b1;
      a1 = {dir_base[31:12], 12'h000} + {20'h0, va[31:22], 2'b00};
      mem[a1] = e1;
      a2 = {e1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
      if (a2 != a1) mem[a2] = e2;
      issue(va, wr);
    end
    wait_idle();
    repeat (4) @(negedge clk);
    chk(etag_q.size() == 0 && xa_q.size() == 0, "R9 one result per request",
        64'(etag_q.size()), 64'd0);
    finish_run();
  end
endmodule